// File: doc/BRIEF.md
# Edge-Selectable Up/Down Event Counter

This block is a 16-bit counter clocked by the module clock. It counts transitions seen on an asynchronous count pin. The pin passes through a two-stage synchroniser. An edge is found by comparing the newest synchronised sample with the one taken a cycle before.

A coded edge-select field picks the transitions that count: rising, falling or both. One code disables counting, and the remaining codes are reserved and also count nothing. Counting requires two things: the mode field must select event counting and the run bit must be set.

The direction comes from a software bit. When external direction is enabled, that bit is combined by XOR with a synchronised direction pin. Each wrap of the count in either direction flips a toggle output and raises a one-cycle interrupt pulse. Software sets the whole control word in one write strobe, and it can load the count at any time.

Top module: `evt_counter`

## Requirements
- R1: After reset the count, the toggle output and the interrupt are 0, and all control fields are cleared, so no counting occurs until a control write.
- R2: A count step happens only while the mode field is 3'b001 and the run bit is 1. Any other mode, or run at 0, leaves the count unchanged.
- R3: Edge code 3'b001 counts rising transitions of the count pin only.
- R4: Edge code 3'b010 counts falling transitions of the count pin only.
- R5: Edge code 3'b011 counts both rising and falling transitions.
- R6: Edge code 3'b000 and every code with bit 2 set produce no count steps.
- R7: With external direction disabled, direction bit 0 counts up by one per event and 1 counts down by one.
- R8: With external direction enabled, the effective direction is the direction bit XOR the synchronised direction pin, using the same encoding as R7.
- R9: An up step from 0xFFFF gives 0x0000. In that same update the toggle output inverts and the interrupt is high for exactly one cycle.
- R10: A down step from 0x0000 gives 0xFFFF. In that same update the toggle output inverts and the interrupt is high for exactly one cycle.
- R11: A count load takes effect at the next clock edge and wins over a count event in the same cycle. A load raises no interrupt and leaves the toggle output unchanged.
- R12: A change on the count pin shows in the count at the third rising clock edge after the change, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| ctl_we | input | 1 | Writes the control fields below |
| ctl_mode | input | 3 | Mode field; 3'b001 selects event counting |
| ctl_edge | input | 3 | Edge-select code |
| ctl_run | input | 1 | Run bit |
| ctl_dir | input | 1 | Direction bit, 0 up, 1 down |
| ctl_xden | input | 1 | Enables the external direction pin |
| ld_we | input | 1 | Loads ld_val into the count |
| ld_val | input | WIDTH | Load value |
| cnt_pin | input | 1 | Asynchronous count input |
| dir_pin | input | 1 | Asynchronous external direction input |
| count | output | WIDTH | Current count |
| tgl_out | output | 1 | Toggle latch output |
| irq | output | 1 | One-cycle wrap interrupt |

## Verification
A change on the count pin is due in the count three clock edges after it is driven. The result is checked once at the second edge, where the count must still hold its old value, and once at the third, where the step, the toggle flip and the interrupt must all appear. A load or a control write is due one edge after its strobe. Each expectation goes into a queue tagged with its due cycle, and it is compared only at the falling clock edge of that exact cycle. The pins are held for four cycles between changes, so an interrupt from one event has cleared before the next event is scored.

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [2:0]       ctl_mode,
  input  logic [2:0]       ctl_edge,
  input  logic             ctl_run,
  input  logic             ctl_dir,
  input  logic             ctl_xden,
  input  logic             ld_we,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             cnt_pin,
  input  logic             dir_pin,
  output logic [WIDTH-1:0] count,
  output logic             tgl_out,
  output logic             irq
);
  localparam logic [2:0] MODE_EVT = 3'b001;

  logic [2:0]       mode_q, edge_q;
  logic             run_q, dir_q, xden_q;
  logic [1:0]       in_sync, dp_sync;
  logic             in_prev;
  logic [WIDTH-1:0] cnt_q;
  logic             tgl_q, irq_q;
  logic             rise, fall, hit, step, down, at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      edge_q <= '0;
      run_q  <= 1'b0;
      dir_q  <= 1'b0;
      xden_q <= 1'b0;
    end else if (ctl_we) begin
      mode_q <= ctl_mode;
      edge_q <= ctl_edge;
      run_q  <= ctl_run;
      dir_q  <= ctl_dir;
      xden_q <= ctl_xden;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_sync <= '0;
      dp_sync <= '0;
      in_prev <= 1'b0;
    end else begin
      in_sync <= {in_sync[0], cnt_pin};
      dp_sync <= {dp_sync[0], dir_pin};
      in_prev <= in_sync[1];
    end
  end

  assign rise = in_sync[1] & ~in_prev;
  assign fall = ~in_sync[1] & in_prev;

  always_comb begin
    case (edge_q)
      3'b001:  hit = rise;
      3'b010:  hit = fall;
      3'b011:  hit = rise | fall;
      default: hit = 1'b0;
    endcase
  end

  assign step   = hit && run_q && (mode_q == MODE_EVT);
  assign down   = xden_q ? (dir_q ^ dp_sync[1]) : dir_q;
  assign at_end = down ? (cnt_q == '0) : (&cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (ld_we) begin
      cnt_q <= ld_val;
      irq_q <= 1'b0;
    end else if (step) begin
      cnt_q <= down ? cnt_q - 1'b1 : cnt_q + 1'b1;
      irq_q <= at_end;
      tgl_q <= tgl_q ^ at_end;
    end else begin
      irq_q <= 1'b0;
    end
  end

  assign count   = cnt_q;
  assign tgl_out = tgl_q;
  assign irq     = irq_q;

  p_unit_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_we) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 ||
                       cnt_q == $past(cnt_q) - 1'b1));

  p_idle_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ld_we) && ($past(edge_q[2]) || $past(edge_q) == 3'b000)) |-> $stable(cnt_q));

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ld_we) && (!$past(run_q) || $past(mode_q) != MODE_EVT)) |-> $stable(cnt_q));

  p_tgl_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tgl_q) |-> irq_q);

  p_irq_tgl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !$stable(tgl_q));

  p_wrap_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_q == '0 || (&cnt_q)));

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_we) |-> (cnt_q == $past(ld_val) && !irq_q && $stable(tgl_q)));
endmodule

// File: tb/sim_evt_counter.sv
`timescale 1ns/1ps
module sim_evt_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, ctl_run = 1'b0, ctl_dir = 1'b0, ctl_xden = 1'b0;
  logic [2:0]  ctl_mode = '0, ctl_edge = '0;
  logic        ld_we = 1'b0;
  logic [15:0] ld_val = '0;
  logic        cnt_pin = 1'b0, dir_pin = 1'b0;
  logic [15:0] count;
  logic        tgl_out, irq;

  evt_counter #(.WIDTH(16)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_mode(ctl_mode), .ctl_edge(ctl_edge),
    .ctl_run(ctl_run), .ctl_dir(ctl_dir), .ctl_xden(ctl_xden), .ld_we(ld_we),
    .ld_val(ld_val), .cnt_pin(cnt_pin), .dir_pin(dir_pin), .count(count),
    .tgl_out(tgl_out), .irq(irq)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int          q_due[$];
  logic [15:0] q_cnt[$];
  bit          q_tgl[$], q_irq[$];
  string       q_req[$];

  logic [15:0] m_cnt = '0;
  bit m_tgl = 0, m_run = 0, m_dir = 0, m_xd = 0, m_pin = 0, m_dpin = 0;
  logic [2:0] m_mode = '0, m_edge = '0;

  task automatic push(int due, string req, logic [15:0] c, bit t, bit i);
    q_due.push_back(due); q_req.push_back(req);
    q_cnt.push_back(c); q_tgl.push_back(t); q_irq.push_back(i);
  endtask

  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      automatic string r = q_req.pop_front();
      automatic logic [15:0] c = q_cnt.pop_front();
      automatic bit t = q_tgl.pop_front();
      automatic bit i = q_irq.pop_front();
      void'(q_due.pop_front());
      checks++;
      if (count !== c || tgl_out !== t || irq !== i) begin
        errors++;
        $display("FAIL %s cyc=%0d count=%h/%h tgl=%b/%b irq=%b/%b (actual/expected)",
                 r, cyc, count, c, tgl_out, t, irq, i);
      end
    end
  end

  task automatic wr_ctl(logic [2:0] md, logic [2:0] ed, bit run, bit dir, bit xd);
    @(negedge clk);
    ctl_we = 1; ctl_mode = md; ctl_edge = ed; ctl_run = run; ctl_dir = dir; ctl_xden = xd;
    m_mode = md; m_edge = ed; m_run = run; m_dir = dir; m_xd = xd;
    @(negedge clk);
    ctl_we = 0;
  endtask

  function automatic bit qualifies(bit v);
    bit r, f;
    r = v && !m_pin;
    f = !v && m_pin;
    if (m_mode != 3'b001 || !m_run) return 0;
    case (m_edge)
      3'b001:  return r;
      3'b010:  return f;
      3'b011:  return r | f;
      default: return 0;
    endcase
  endfunction

  task automatic set_pin(bit v, string req);
    bit dn, wrap;
    @(negedge clk);
    cnt_pin = v;
    push(cyc + 2, "R12", m_cnt, m_tgl, 0);
    wrap = 0;
    if (qualifies(v)) begin
      dn = m_xd ? (m_dir ^ m_dpin) : m_dir;
      wrap = dn ? (m_cnt == 16'h0000) : (m_cnt == 16'hFFFF);
      m_cnt = dn ? m_cnt - 16'd1 : m_cnt + 16'd1;
      if (wrap) m_tgl = !m_tgl;
    end
    m_pin = v;
    push(cyc + 3, req, m_cnt, m_tgl, wrap);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_dpin(bit v);
    @(negedge clk);
    dir_pin = v; m_dpin = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_load(logic [15:0] v);
    @(negedge clk);
    ld_we = 1; ld_val = v; m_cnt = v;
    push(cyc + 1, "R11", v, m_tgl, 0);
    @(negedge clk);
    ld_we = 0;
    @(negedge clk);
  endtask

  task automatic pin_with_load(bit v, logic [15:0] lv);
    @(negedge clk);
    cnt_pin = v;
    push(cyc + 2, "R12", m_cnt, m_tgl, 0);
    m_pin = v;
    @(negedge clk);
    @(negedge clk);
    ld_we = 1; ld_val = lv; m_cnt = lv;
    push(cyc + 1, "R11", lv, m_tgl, 0);
    @(negedge clk);
    ld_we = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (count !== 16'h0 || tgl_out !== 1'b0 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1 count=%h/0000 tgl=%b/0 irq=%b/0 (actual/expected)", count, tgl_out, irq);
    end
    set_pin(1, "R1"); set_pin(0, "R1");
    wr_ctl(3'b001, 3'b001, 1, 0, 0);
    set_pin(1, "R3"); set_pin(0, "R3"); set_pin(1, "R3");
    wr_ctl(3'b001, 3'b010, 1, 0, 0);
    set_pin(0, "R4"); set_pin(1, "R4"); set_pin(0, "R4");
    wr_ctl(3'b001, 3'b011, 1, 0, 0);
    set_pin(1, "R5"); set_pin(0, "R5");
    wr_ctl(3'b001, 3'b000, 1, 0, 0);
    set_pin(1, "R6"); set_pin(0, "R6");
    wr_ctl(3'b001, 3'b100, 1, 0, 0);
    set_pin(1, "R6"); set_pin(0, "R6");
    wr_ctl(3'b001, 3'b111, 1, 0, 0);
    set_pin(1, "R6"); set_pin(0, "R6");
    wr_ctl(3'b010, 3'b011, 1, 0, 0);
    set_pin(1, "R2"); set_pin(0, "R2");
    wr_ctl(3'b001, 3'b011, 0, 0, 0);
    set_pin(1, "R2"); set_pin(0, "R2");
    wr_ctl(3'b001, 3'b011, 1, 1, 0);
    set_pin(1, "R7"); set_pin(0, "R7");
    set_dpin(1);
    wr_ctl(3'b001, 3'b011, 1, 1, 1);
    set_pin(1, "R8"); set_pin(0, "R8");
    wr_ctl(3'b001, 3'b011, 1, 0, 1);
    set_pin(1, "R8");
    set_dpin(0);
    set_pin(0, "R8");
    wr_ctl(3'b001, 3'b011, 1, 0, 0);
    do_load(16'hFFFE);
    set_pin(1, "R9"); set_pin(0, "R9"); set_pin(1, "R9");
    wr_ctl(3'b001, 3'b011, 1, 1, 0);
    set_pin(0, "R10"); set_pin(1, "R10");
    pin_with_load(0, 16'h1234);
    set_pin(1, "R11");
    repeat (6) @(negedge clk);
    if (q_due.size() != 0) begin
      errors++;
      $display("FAIL R12 pending=%0d/0 (actual/expected)", q_due.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog cyc=%0d/<20000 (actual/expected)", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule